// File: doc/BRIEF.md
# Nibble-Wide Host Command Port

This block is the slave side of a narrow command link between a host controller and an on-chip register file. The host owns a 4-bit data bus, a bus clock that idles high and an active-low select. The port accepts write commands as a command byte and a data byte, each sent as a high nibble followed by a low nibble. Two command prefixes also carry a second data byte. The port also accepts read commands, which return a number of nibbles that depends on the command. It drives a status nibble while a transaction is opening, and it closes each transaction with a parity nibble that lets the host check the transfer.

All host pins pass through a two-flop synchronizer into the system clock. Edges of the bus clock are detected in that domain. Nibbles from the host are taken on bus clock rising edges, and nibbles the port drives change on falling edges. The bus is split into an input, an output and an output enable, so the pad ring can build the bidirectional pin. A completed write is handed to the register file as a one-cycle strobe with the command and data. Reads fetch each nibble from the register file through a command and index lookup.

Top module: `nib_host_port`

## Requirements
- R1: After reset, bus_oe_o and wr_valid_o are 0.
- R2: After select goes low with no transaction open, the port drives status_i onto bus_d_o with bus_oe_o=1. It releases the bus (bus_oe_o=0) at the first falling edge of the bus clock.
- R3: Rising edges of the bus clock after that release capture, in order, the command high nibble, the command low nibble, the data high nibble and the data low nibble. After the last of these, wr_valid_o pulses for exactly one cycle. With the pulse, wr_cmd_o shows the command, wr_data_o shows the data and wr_long_o is 0.
- R4: A write whose command high nibble is 0xB or 0xF takes two more nibbles, high then low, into wr_ext_o. Its pulse reports wr_long_o=1.
- R5: At the first falling edge after the last written nibble, the port drives the XOR of all written nibbles with bus_oe_o=1. It holds that value until select goes high. wr_valid_o is never high while bus_oe_o is 1.
- R6: A command with bit 7 set and a high nibble other than 0xB or 0xF is a read. At the k-th falling edge after the command low nibble (k=0..N-1), the port drives rd_nib_i, taken while rd_idx_o=k and rd_cmd_o shows the command. N is the value in entry cmd[2:0] of the length table 2,1,4,3,6,5,8,7, listed for entries 0 to 7.
- R7: At the falling edge after the last read nibble, the port drives the XOR of the two command nibbles and all read nibbles, and holds it until select goes high.
- R8: Select going high releases the bus within four system cycles. It also abandons an unfinished write without a wr_valid_o pulse, and the next select-low opens a fresh transaction with the status nibble.
- R9: A read command never produces a wr_valid_o pulse, and no pulse ever reports a read command.
- R10: Extra bus clock cycles after the parity nibble leave bus_d_o and bus_oe_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Host bus clock, idles high |
| bus_cs_n_i | input | 1 | Host select, active low |
| bus_d_i | input | 4 | Nibble from host |
| bus_d_o | output | 4 | Nibble to host |
| bus_oe_o | output | 1 | Port drives the bus |
| status_i | input | 4 | Status nibble shown at transaction start |
| wr_valid_o | output | 1 | One-cycle strobe for a completed write |
| wr_cmd_o | output | 8 | Written command |
| wr_data_o | output | 8 | Written data byte |
| wr_ext_o | output | 8 | Extra data byte of a long write |
| wr_long_o | output | 1 | Write carried the extra byte |
| rd_cmd_o | output | 8 | Command for read lookup |
| rd_idx_o | output | 4 | Index of the read nibble being fetched |
| rd_nib_i | input | 4 | Read nibble from the register file |

## Verification
Short writes use random command and data values. These show whether the nibble order into each field is right and whether the parity covers every nibble. Long writes with both extra prefixes, mixed with short writes whose high nibble differs by one bit, show whether the long class is decoded from the prefix alone. Reads of each table entry, including the one-nibble and eight-nibble ends, use a data pattern that changes with both command and index, so a miscounted length or an index slip shows in both the read nibbles and the parity. An aborted write followed by a normal one shows that state left from the unfinished transfer neither strobes nor carries into the next transaction.

// File: rtl/nhp_pkg.sv
package nhp_pkg;

    localparam int NIB_W   = 4;
    localparam int LEN_W   = 4;
    localparam int TAB_N   = 8;
    localparam int TAB_SEL = $clog2(TAB_N);
    localparam int CNT_W   = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STAT,
        PH_WR,
        PH_RD,
        PH_PARW,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic             clk;
        logic             cs_n;
        logic [NIB_W-1:0] d;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    function automatic logic is_long(input logic [NIB_W-1:0] hi,
                                     input logic [NIB_W-1:0] pa,
                                     input logic [NIB_W-1:0] pb);
        return (hi == pa) || (hi == pb);
    endfunction

    function automatic logic is_read(input logic [2*NIB_W-1:0] cmd,
                                     input logic [NIB_W-1:0] pa,
                                     input logic [NIB_W-1:0] pb);
        return cmd[2*NIB_W-1] && !is_long(cmd[2*NIB_W-1:NIB_W], pa, pb);
    endfunction

    function automatic logic [LEN_W-1:0] tab_len(input logic [TAB_N*LEN_W-1:0] tab,
                                                 input logic [TAB_SEL-1:0] sel);
        return tab[int'(sel)*LEN_W +: LEN_W];
    endfunction

endpackage

// File: rtl/nhp_pin_sync.sv
module nhp_pin_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] s1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i]     <= RST_VAL[i];
                q[i]      <= RST_VAL[i];
                q_prev[i] <= RST_VAL[i];
            end else begin
                s1[i]     <= din[i];
                q[i]      <= s1[i];
                q_prev[i] <= q[i];
            end
        end
    end
endmodule

// File: rtl/nhp_seq.sv
module nhp_seq
    import nhp_pkg::*;
#(
    parameter logic [NIB_W-1:0]       LONG_HI_A    = 4'hB,
    parameter logic [NIB_W-1:0]       LONG_HI_B    = 4'hF,
    parameter logic [TAB_N*LEN_W-1:0] RD_LEN_TABLE = 32'h7856_3412
) (
    input  logic               clk,
    input  logic               rst,
    input  pins_t              cur,
    input  pins_t              prv,
    input  logic [NIB_W-1:0]   status_i,
    input  logic [NIB_W-1:0]   rd_nib_i,
    output logic [NIB_W-1:0]   bus_d_o,
    output logic               bus_oe_o,
    output logic               wr_valid_o,
    output logic [2*NIB_W-1:0] wr_cmd_o,
    output logic [2*NIB_W-1:0] wr_data_o,
    output logic [2*NIB_W-1:0] wr_ext_o,
    output logic               wr_long_o,
    output logic [LEN_W-1:0]   rd_idx_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    phase_e             ph;
    logic [CNT_W-1:0]   cnt;
    logic [NIB_W-1:0]   par;
    logic [LEN_W-1:0]   rlen;
    logic               b_rise, b_fall, sel;
    logic [2*NIB_W-1:0] cmd_next;

    assign b_rise   = cur.clk & ~prv.clk;
    assign b_fall   = ~cur.clk & prv.clk;
    assign sel      = ~cur.cs_n;
    assign cmd_next = {wr_cmd_o[2*NIB_W-1:NIB_W], cur.d};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            cnt        <= '0;
            par        <= '0;
            rlen       <= '0;
            rd_idx_o   <= '0;
            bus_d_o    <= '0;
            bus_oe_o   <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_cmd_o   <= '0;
            wr_data_o  <= '0;
            wr_ext_o   <= '0;
            wr_long_o  <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            if (!sel) begin
                ph       <= PH_IDLE;
                bus_oe_o <= 1'b0;
                cnt      <= '0;
                par      <= '0;
                rd_idx_o <= '0;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        ph       <= PH_STAT;
                        bus_d_o  <= status_i;
                        bus_oe_o <= 1'b1;
                        cnt      <= '0;
                        par      <= '0;
                        rd_idx_o <= '0;
                        wr_ext_o <= '0;
                    end
                    PH_STAT: if (b_fall) begin
                        bus_oe_o <= 1'b0;
                        ph       <= PH_WR;
                    end
                    PH_WR: if (b_rise) begin
                        par <= par ^ cur.d;
                        cnt <= cnt + CNT_W'(1);
                        unique case (cnt)
                            3'd0: wr_cmd_o[2*NIB_W-1:NIB_W] <= cur.d;
                            3'd1: begin
                                wr_cmd_o[NIB_W-1:0] <= cur.d;
                                if (is_read(cmd_next, LONG_HI_A, LONG_HI_B)) begin
                                    ph   <= PH_RD;
                                    rlen <= tab_len(RD_LEN_TABLE, cur.d[TAB_SEL-1:0]);
                                end
                            end
                            3'd2: wr_data_o[2*NIB_W-1:NIB_W] <= cur.d;
                            3'd3: begin
                                wr_data_o[NIB_W-1:0] <= cur.d;
                                if (!is_long(wr_cmd_o[2*NIB_W-1:NIB_W], LONG_HI_A, LONG_HI_B)) begin
                                    ph         <= PH_PARW;
                                    wr_valid_o <= 1'b1;
                                    wr_long_o  <= 1'b0;
                                end
                            end
                            3'd4: wr_ext_o[2*NIB_W-1:NIB_W] <= cur.d;
                            default: begin
                                wr_ext_o[NIB_W-1:0] <= cur.d;
                                ph         <= PH_PARW;
                                wr_valid_o <= 1'b1;
                                wr_long_o  <= 1'b1;
                            end
                        endcase
                    end
                    PH_RD: if (b_fall) begin
                        bus_d_o  <= rd_nib_i;
                        bus_oe_o <= 1'b1;
                        par      <= par ^ rd_nib_i;
                        rd_idx_o <= rd_idx_o + ONE;
                        if ((rd_idx_o + ONE) == rlen) ph <= PH_PARW;
                    end
                    PH_PARW: if (b_fall) begin
                        bus_d_o  <= par;
                        bus_oe_o <= 1'b1;
                        ph       <= PH_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nib_host_port.sv
module nib_host_port
    import nhp_pkg::*;
#(
    parameter logic [3:0]  LONG_HI_A    = 4'hB,
    parameter logic [3:0]  LONG_HI_B    = 4'hF,
    parameter logic [31:0] RD_LEN_TABLE = 32'h7856_3412
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_clk_i,
    input  logic       bus_cs_n_i,
    input  logic [3:0] bus_d_i,
    output logic [3:0] bus_d_o,
    output logic       bus_oe_o,
    input  logic [3:0] status_i,
    output logic       wr_valid_o,
    output logic [7:0] wr_cmd_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] wr_ext_o,
    output logic       wr_long_o,
    output logic [7:0] rd_cmd_o,
    output logic [3:0] rd_idx_o,
    input  logic [3:0] rd_nib_i
);
    localparam pins_t PIN_IDLE = '{clk: 1'b1, cs_n: 1'b1, d: '0};

    pins_t             raw;
    logic [PIN_W-1:0]  cur_v, prv_v;

    assign raw = '{clk: bus_clk_i, cs_n: bus_cs_n_i, d: bus_d_i};

    nhp_pin_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (raw),
        .q      (cur_v),
        .q_prev (prv_v)
    );

    nhp_seq #(
        .LONG_HI_A    (LONG_HI_A),
        .LONG_HI_B    (LONG_HI_B),
        .RD_LEN_TABLE (RD_LEN_TABLE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cur        (pins_t'(cur_v)),
        .prv        (pins_t'(prv_v)),
        .status_i   (status_i),
        .rd_nib_i   (rd_nib_i),
        .bus_d_o    (bus_d_o),
        .bus_oe_o   (bus_oe_o),
        .wr_valid_o (wr_valid_o),
        .wr_cmd_o   (wr_cmd_o),
        .wr_data_o  (wr_data_o),
        .wr_ext_o   (wr_ext_o),
        .wr_long_o  (wr_long_o),
        .rd_idx_o   (rd_idx_o)
    );

    assign rd_cmd_o = wr_cmd_o;
endmodule

// File: rtl/nhp_host_port_chk.sv
module nhp_host_port_chk #(
    parameter logic [3:0] LONG_HI_A = 4'hB,
    parameter logic [3:0] LONG_HI_B = 4'hF
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_cs_n_i,
    input logic       bus_oe_o,
    input logic       wr_valid_o,
    input logic [7:0] wr_cmd_o
);
    logic [2:0] cs_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !bus_cs_n_i) cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
    end

    // R1 and R8: bus released once select has been high long enough
    a_r8_bus_released: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= 3'd4) |-> !bus_oe_o);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |=> !wr_valid_o);

    a_r5_pulse_not_driving: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> !bus_oe_o);

    a_r9_no_read_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> (!wr_cmd_o[7] || wr_cmd_o[7:4] == LONG_HI_A || wr_cmd_o[7:4] == LONG_HI_B));
endmodule

bind nib_host_port nhp_host_port_chk #(
    .LONG_HI_A (LONG_HI_A),
    .LONG_HI_B (LONG_HI_B)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_cs_n_i (bus_cs_n_i),
    .bus_oe_o   (bus_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_cmd_o   (wr_cmd_o)
);

// File: tb/nib_host_port_test.sv
module nib_host_port_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_clk_i = 1'b1;
    logic       bus_cs_n_i = 1'b1;
    logic [3:0] bus_d_i = '0;
    logic [3:0] bus_d_o;
    logic       bus_oe_o;
    logic [3:0] status_i = '0;
    logic       wr_valid_o;
    logic [7:0] wr_cmd_o, wr_data_o, wr_ext_o, rd_cmd_o;
    logic       wr_long_o;
    logic [3:0] rd_idx_o, rd_nib_i;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    logic [7:0] cap_cmd, cap_data, cap_ext;
    logic       cap_long;
    bit         done = 0;

    always #5 clk = ~clk;

    nib_host_port uut (
        .clk(clk), .rst(rst), .bus_clk_i(bus_clk_i), .bus_cs_n_i(bus_cs_n_i),
        .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_oe_o(bus_oe_o), .status_i(status_i),
        .wr_valid_o(wr_valid_o), .wr_cmd_o(wr_cmd_o), .wr_data_o(wr_data_o),
        .wr_ext_o(wr_ext_o), .wr_long_o(wr_long_o), .rd_cmd_o(rd_cmd_o),
        .rd_idx_o(rd_idx_o), .rd_nib_i(rd_nib_i)
    );

    function automatic logic [3:0] rd_model(input logic [7:0] c, input logic [3:0] k);
        return c[3:0] ^ c[7:4] ^ k;
    endfunction

    assign rd_nib_i = rd_model(rd_cmd_o, rd_idx_o);

    function automatic int len_of(input logic [2:0] s);
        case (s)
            3'd0: return 2;  3'd1: return 1;  3'd2: return 4;  3'd3: return 3;
            3'd4: return 6;  3'd5: return 5;  3'd6: return 8;  default: return 7;
        endcase
    endfunction

    function automatic bit long_cmd(input logic [7:0] c);
        return c[7:4] == 4'hB || c[7:4] == 4'hF;
    endfunction

    always @(negedge clk) begin
        if (wr_valid_o) begin
            pulses++;
            cap_cmd  = wr_cmd_o;
            cap_data = wr_data_o;
            cap_ext  = wr_ext_o;
            cap_long = wr_long_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hhalf();
        repeat (H) @(negedge clk);
    endtask

    task automatic open_txn(input logic [3:0] st);
        status_i = st;
        bus_cs_n_i = 1'b0;
        hhalf();
        chk(bus_oe_o && bus_d_o == st, "R2 status nibble", {bus_oe_o, bus_d_o}, {1'b1, st});
    endtask

    task automatic close_txn();
        bus_cs_n_i = 1'b1;
        hhalf();
        chk(!bus_oe_o, "R8 release on select high", bus_oe_o, 0);
    endtask

    task automatic send_nib(input int k, input logic [3:0] v);
        bus_clk_i = 1'b0;
        hhalf();
        if (k == 0) chk(!bus_oe_o, "R2 release at first fall", bus_oe_o, 0);
        bus_d_i = v;
        bus_clk_i = 1'b1;
        hhalf();
    endtask

    task automatic do_write(input logic [7:0] c, input logic [7:0] d, input logic [7:0] e,
                            input logic [3:0] st);
        logic [3:0] nib [6];
        logic [3:0] par = '0;
        int n = long_cmd(c) ? 6 : 4;
        int p0 = pulses;
        nib[0] = c[7:4]; nib[1] = c[3:0]; nib[2] = d[7:4];
        nib[3] = d[3:0]; nib[4] = e[7:4]; nib[5] = e[3:0];
        open_txn(st);
        for (int k = 0; k < n; k++) begin
            send_nib(k, nib[k]);
            par ^= nib[k];
        end
        bus_clk_i = 1'b0; hhalf();
        chk(bus_oe_o && bus_d_o == par, "R5 write parity", {bus_oe_o, bus_d_o}, {1'b1, par});
        bus_clk_i = 1'b1; hhalf();
        bus_clk_i = 1'b0; hhalf();
        chk(bus_oe_o && bus_d_o == par, "R10 extra clock after parity", {bus_oe_o, bus_d_o}, {1'b1, par});
        bus_clk_i = 1'b1; hhalf();
        close_txn();
        chk(pulses == p0 + 1, "R3 one strobe per write", pulses - p0, 1);
        chk(cap_cmd == c && cap_data == d, "R3 command and data", {cap_cmd, cap_data}, {c, d});
        if (n == 6) begin
            chk(cap_long && cap_ext == e, "R4 long write extra byte", {cap_long, cap_ext}, {1'b1, e});
        end else begin
            chk(!cap_long, "R4 short write flag", cap_long, 0);
        end
    endtask

    task automatic do_read(input logic [7:0] c, input logic [3:0] st);
        int n = len_of(c[2:0]);
        int p0 = pulses;
        logic [3:0] par = c[7:4] ^ c[3:0];
        logic [3:0] ex;
        open_txn(st);
        send_nib(0, c[7:4]);
        send_nib(1, c[3:0]);
        for (int k = 0; k < n; k++) begin
            bus_clk_i = 1'b0; hhalf();
            ex = rd_model(c, 4'(k));
            par ^= ex;
            chk(bus_oe_o && bus_d_o == ex, "R6 read nibble", {bus_oe_o, bus_d_o}, {1'b1, ex});
            bus_clk_i = 1'b1; hhalf();
        end
        bus_clk_i = 1'b0; hhalf();
        chk(bus_oe_o && bus_d_o == par, "R7 read parity", {bus_oe_o, bus_d_o}, {1'b1, par});
        bus_clk_i = 1'b1; hhalf();
        close_txn();
        chk(pulses == p0, "R9 no strobe on read", pulses - p0, 0);
    endtask

    task automatic do_abort(input logic [7:0] c, input logic [3:0] dh);
        int p0 = pulses;
        open_txn(4'h5);
        send_nib(0, c[7:4]);
        send_nib(1, c[3:0]);
        send_nib(2, dh);
        close_txn();
        chk(pulses == p0, "R8 abandoned write has no strobe", pulses - p0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] c, d, e;
        void'($urandom(32'd4021));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!bus_oe_o && !wr_valid_o, "R1 reset state", {bus_oe_o, wr_valid_o}, 0);

        do_write(8'h12, 8'h34, 8'h00, 4'hA);
        do_write(8'hB5, 8'hC3, 8'h9E, 4'h3);
        do_write(8'hF0, 8'h0F, 8'h71, 4'hC);
        do_write(8'h7A, 8'hFF, 8'h00, 4'h0);
        do_read(8'h80, 4'h6);
        do_read(8'h81, 4'h9);
        do_read(8'h86, 4'h1);
        do_read(8'hE7, 4'hF);
        do_abort(8'h23, 4'h4);
        do_write(8'h45, 8'h67, 8'h00, 4'h2);

        for (int i = 0; i < 24; i++) begin
            c = 8'($urandom); d = 8'($urandom); e = 8'($urandom);
            if (c[7] && !long_cmd(c)) c[7] = 1'b0;
            do_write(c, d, e, 4'($urandom));
        end
        for (int i = 0; i < 16; i++) begin
            c = {1'b1, 7'($urandom)};
            if (long_cmd(c)) c[7:4] = 4'h9;
            do_read(c, 4'($urandom));
        end
        for (int s = 0; s < 8; s++) do_read({5'b11000, 3'(s)}, 4'(s));
        finish_run();
    end
endmodule